// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A four-bit synchronous binary counter. On each rising clock edge it steps up or down by one, or holds its value. An active-low count enable gates the step, and a single direction line sets which way the count moves. An active-low preset input overrides counting. While it is low, the count output follows the data inputs at any clock level. When it is released, the counter keeps the value that was presented.

Two combinational outputs support chaining. The terminal flag is high while the count sits at its last value in the current direction: all ones when counting up, zero when counting down. The active-low ripple output repeats that condition, but only during the low half of the clock and only while counting is enabled. Feeding one stage's ripple output into the next stage's enable, with a shared clock, makes a wider counter.

Top module: `updn_counter`

The internal mode decoder names three states for the next edge, chosen from the enable and direction lines. MODE_HOLD keeps the count when enable is high. MODE_UP adds one when enable is low and direction is low. MODE_DOWN subtracts one when enable is low and direction is high. The asynchronous preset path sits above all three modes.

## Requirements
- R1: With preset high and en_n high at a rising edge, the count keeps its value.
- R2: With preset high, en_n low and dir_down low at a rising edge, the count goes up by one, and 15 wraps to 0.
- R3: With preset high, en_n low and dir_down high at a rising edge, the count goes down by one, and 0 wraps to 15.
- R4: While load_n is low, count_o equals data_i with no clock edge needed, whatever the enable level. After load_n rises, with data_i held since the last clock edge, the count keeps that value.
- R5: Changes to en_n or dir_down between rising edges leave count_o unchanged.
- R6: term_o is high exactly when dir_down is low and count_o is all ones, or when dir_down is high and count_o is zero. It follows a direction change at once.
- R7: ripple_n_o is low exactly when term_o is high, en_n is low and clk is low. It is high at all other times.
- R8: Two stages sharing clk, load_n and dir_down, with the upper stage's en_n fed from the lower stage's ripple_n_o, count as one eight-bit up/down counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| load_n | input | 1 | Active-low asynchronous preset |
| en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| data_i | input | W | Preset value |
| count_o | output | W | Current count |
| term_o | output | 1 | Terminal-count flag for the current direction |
| ripple_n_o | output | 1 | Active-low carry/borrow, valid in the clock's low half |

## Verification
Two instances are chained into an eight-bit counter. The bench presets every lower-nibble value in both directions and then runs twenty edges from each. An enable pattern that idles one edge in seven separates hold from stepping and shows that the upper stage advances only across a nibble boundary. Starting values 0xFF going up and 0x00 going down show the wrap in each direction. The flag and ripple outputs are sampled in both clock phases after each input change, which separates the clock gating from the direction gating. Flipping enable and direction between edges shows that those inputs act only at an edge.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD,
        MODE_UP,
        MODE_DOWN
    } mode_e;
endpackage

// File: rtl/updn_mode_sel.sv
module updn_mode_sel
    import updn_pkg::*;
(
    input  logic  en_n,
    input  logic  dir_down,
    output mode_e mode
);
    always_comb begin
        if (en_n)          mode = MODE_HOLD;
        else if (dir_down) mode = MODE_DOWN;
        else               mode = MODE_UP;
    end
endmodule

// File: rtl/updn_step.sv
module updn_step
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  mode_e          mode,
    input  logic [W-1:0]   cur,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (mode)
            MODE_UP:   nxt = cur + ONE;
            MODE_DOWN: nxt = cur - ONE;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_flag.sv
module updn_flag #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         en_n,
    input  logic         dir_down,
    input  logic [W-1:0] cnt,
    output logic         term,
    output logic         ripple_n
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ALL_ZERO = '0;

    always_comb begin
        term     = dir_down ? (cnt == ALL_ZERO) : (cnt == ALL_ONES);
        ripple_n = ~(term & ~clk & ~en_n);
    end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic         en_n,
    input  logic         dir_down,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] count_o,
    output logic         term_o,
    output logic         ripple_n_o
);
    mode_e        mode;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    updn_mode_sel u_mode (
        .en_n     (en_n),
        .dir_down (dir_down),
        .mode     (mode)
    );

    updn_step #(.W(W)) u_step (
        .mode (mode),
        .cur  (cnt_q),
        .nxt  (cnt_nxt)
    );

    // count register: asynchronous preset has priority over the edge step
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) cnt_q <= data_i;
        else         cnt_q <= cnt_nxt;
    end

    // output process: preset is transparent while held low
    always_comb begin
        count_o = load_n ? cnt_q : data_i;
    end

    updn_flag #(.W(W)) u_flag (
        .clk      (clk),
        .en_n     (en_n),
        .dir_down (dir_down),
        .cnt      (count_o),
        .term     (term_o),
        .ripple_n (ripple_n_o)
    );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         load_n,
    input logic         en_n,
    input logic         dir_down,
    input logic [W-1:0] data_i,
    input logic [W-1:0] count_o,
    input logic         term_o,
    input logic         ripple_n_o
);
    logic armed = 1'b0;
    always_ff @(negedge load_n) armed <= 1'b1;

    a_r1_hold: assert property (@(posedge clk) disable iff (!armed || !load_n)
        en_n |=> count_o == $past(count_o));

    a_r2_up: assert property (@(posedge clk) disable iff (!armed || !load_n)
        (!en_n && !dir_down) |=> count_o == W'($past(count_o) + 1'b1));

    a_r3_down: assert property (@(posedge clk) disable iff (!armed || !load_n)
        (!en_n && dir_down) |=> count_o == W'($past(count_o) - 1'b1));

    a_r4_preset: assert property (@(posedge clk) disable iff (!armed)
        !load_n |-> count_o == data_i);

    a_r6_flag_shape: assert property (@(posedge clk) disable iff (!armed)
        term_o |-> ($countones(count_o) == 0 || $countones(count_o) == W));

    a_r7_ripple_low: assert property (@(posedge clk) disable iff (!armed)
        !ripple_n_o |-> (term_o && !en_n));

    a_r7_ripple_high: assert property (@(negedge clk) disable iff (!armed)
        ripple_n_o);
endmodule

bind updn_counter updn_counter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .load_n     (load_n),
    .en_n       (en_n),
    .dir_down   (dir_down),
    .data_i     (data_i),
    .count_o    (count_o),
    .term_o     (term_o),
    .ripple_n_o (ripple_n_o)
);

// File: tb/test_updn_counter.sv
module test_updn_counter;
    logic       clk = 1'b0;
    logic       load_n = 1'b1;
    logic       en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic [7:0] d8 = 8'h00;
    logic [3:0] lo_q, hi_q;
    logic       lo_term, hi_term, lo_rip_n, hi_rip_n;
    wire        hi_en_n;
    logic [7:0] v8 = 8'h00;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    // models board delay so the upper stage sees the ripple held across the edge
    assign #1 hi_en_n = lo_rip_n;

    updn_counter #(.W(4)) i_updn_counter (
        .clk(clk), .load_n(load_n), .en_n(en_n), .dir_down(dir_down),
        .data_i(d8[3:0]), .count_o(lo_q), .term_o(lo_term), .ripple_n_o(lo_rip_n)
    );

    updn_counter #(.W(4)) i_updn_counter_upper (
        .clk(clk), .load_n(load_n), .en_n(hi_en_n), .dir_down(dir_down),
        .data_i(d8[7:4]), .count_o(hi_q), .term_o(hi_term), .ripple_n_o(hi_rip_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // entered in the clock's low phase
    task automatic do_load(input logic [7:0] v);
        d8 = v; en_n = 1'b0; load_n = 1'b0;
        #1;
        chk("R4 preset without edge", {hi_q, lo_q}, v);
        @(posedge clk); #3;
        chk("R4 preset over enable", {hi_q, lo_q}, v);
        #9;
        load_n = 1'b1;
        #1;
        chk("R4 kept after release", {hi_q, lo_q}, v);
        v8 = v;
    endtask

    // entered in the clock's low phase; leaves in the next low phase
    task automatic cycle(input logic en_v, input logic dn_v);
        logic       exp_term;
        logic [3:0] held;
        en_n = en_v; dir_down = dn_v;
        #1;
        exp_term = dn_v ? (v8[3:0] == 4'd0) : (v8[3:0] == 4'd15);
        chk("R6 terminal flag", lo_term, exp_term);
        chk("R7 ripple low phase", lo_rip_n, !(exp_term && !en_v));
        @(posedge clk);
        if (!en_v) v8 = dn_v ? v8 - 8'd1 : v8 + 8'd1;
        #3;
        if (en_v)      chk("R1 hold", lo_q, v8[3:0]);
        else if (dn_v) chk("R3 down", lo_q, v8[3:0]);
        else           chk("R2 up", lo_q, v8[3:0]);
        chk("R8 chained value", {hi_q, lo_q}, v8);
        chk("R7 ripple high phase", lo_rip_n, 1);
        held = lo_q;
        en_n = ~en_n; dir_down = ~dir_down;
        #1;
        chk("R5 controls between edges", lo_q, held);
        #7;
    endtask

    initial begin
        #1;
        // first preset, with data changed while preset held
        d8 = 8'hCD; en_n = 1'b1; load_n = 1'b0;
        #1;
        chk("R4 preset without edge", {hi_q, lo_q}, 8'hCD);
        d8 = 8'h3A;
        #1;
        chk("R4 output follows data", {hi_q, lo_q}, 8'h3A);
        @(posedge clk); #3;
        chk("R4 held during edge", {hi_q, lo_q}, 8'h3A);
        #9;
        load_n = 1'b1;
        #1;
        chk("R4 kept after release", {hi_q, lo_q}, 8'h3A);
        v8 = 8'h3A;
        cycle(1'b1, 1'b0);

        // reference sequence: 13 up to 2, hold, down to 13
        do_load(8'h0D);
        for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0);
        chk("R2 wrap to low nibble 2", lo_q, 2);
        cycle(1'b1, 1'b0);
        for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1);
        chk("R3 wrap back to 13", lo_q, 13);

        // sweep of all nibble start values in both directions
        for (int dn = 0; dn < 2; dn++) begin
            for (int s = 0; s < 16; s++) begin
                do_load({s[3:0], s[3:0]});
                for (int k = 0; k < 20; k++)
                    cycle((k % 7) == 6, dn[0]);
            end
        end

        // mid-count preset during a run
        do_load(8'h7E);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        do_load(8'h81);
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        chk("R8 borrow across nibble", {hi_q, lo_q}, 8'h7F);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule